// File: doc/BRIEF.md
# Software-Managed Translation Buffer

This block holds the page mappings of a small fully associative address translation cache whose contents are maintained entirely by privileged software. Each of the 32 slots keeps two 32-bit words: a tag word whose bits 31..12 hold a virtual page number, and a data word whose bits 31..12 hold a physical frame number and whose bit 0 marks the mapping usable for translation. Software drives one maintenance command at a time. It supplies the current index, tag and data special-register values, and one cycle later it receives the updated values of those three registers.

Four maintenance commands exist. A search looks up a page. An indexed read and an indexed write access the slot named by the index register. A random write stores into a pseudo-randomly chosen slot, and this choice never picks the four lowest slots, so those four stay pinned. Alongside the maintenance path, a purely combinational translation port maps a lookup virtual address to a physical address and raises a miss flag. The top quarter of the address space never goes through the table.

Top module: `tlb_mmu`

## Requirements
- R1: Reset clears every slot to zero, drives `idx_out`, `hi_out` and `lo_out` to zero and keeps `res_valid` low. After reset, a translation of a low address reports a miss.
- R2: Command code 6'b111010 (search) compares `hi_in[31:12]` with the page field of every slot. On a hit, `idx_out` holds the slot number one cycle later, while `hi_out` and `lo_out` echo `hi_in` and `lo_in`.
- R3: A search that matches no slot returns `idx_out` = 32'h8000_0000.
- R4: Command code 6'b111101 (indexed write) stores `hi_in` and `lo_in` into the slot given by `idx_in[4:0]` and ignores the upper index bits. All three inputs are echoed.
- R5: Command code 6'b111100 (indexed read) returns the tag and data words of slot `idx_in[4:0]` on `hi_out`/`lo_out`, with `idx_out` echoing `idx_in`.
- R6: Command code 6'b111011 (random write) stores both words into slot (r mod 28) + 4. Here r is a counter that advances every clock. The chosen slot number appears on `idx_out`, and slots 0 to 3 are never altered by it.
- R7: For `va` below 32'hC000_0000, a slot whose page matches `va[31:12]` and whose data bit 0 is 1 gives `pa` = {data[31:12], va[11:0]} with `miss` = 0. Otherwise `miss` = 1 and `pa` = 0.
- R8: For `va` at or above 32'hC000_0000, `pa` = {2'b00, va[29:0]} and `miss` = 0, whatever the table holds.
- R9: A search reports a slot whose page lies in the direct-mapped region (C0000h..FFFFFh) like any other slot.
- R10: Any other command code is ignored. No response is produced and no slot changes.
- R11: When several slots match, the search and the translation both use the lowest-numbered one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A maintenance command is presented this cycle |
| cmd_op | input | 6 | Command code |
| idx_in | input | 32 | Current index register value |
| hi_in | input | 32 | Current tag (entry-high) register value |
| lo_in | input | 32 | Current data (entry-low) register value |
| va | input | 32 | Lookup virtual address for translation |
| res_valid | output | 1 | Updated register values are present |
| idx_out | output | 32 | Updated index register value |
| hi_out | output | 32 | Updated tag register value |
| lo_out | output | 32 | Updated data register value |
| pa | output | 32 | Translated physical address |
| miss | output | 1 | Translation found no usable mapping |

## Verification
Several properties are checked on every cycle. The random slot pointer stays inside the replaceable range, at most one slot is granted by each priority encoder, and an unmatched search yields the sentinel. The upper region always bypasses the table, and unknown codes never raise a response. Only the bench's scenarios can show that data written really lands in the slot selected by the low index bits and reads back intact. They also show that the pinned slots survive repeated random writes, that the lowest of several matching slots wins, and that translation honours the usable bit.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int ADDR_W   = 32;
    localparam int PAGE_LSB = 12;
    localparam int PAGE_W   = ADDR_W - PAGE_LSB;

    localparam logic [ADDR_W-1:0] SEARCH_MISS = 32'h8000_0000;

    typedef enum logic [5:0] {
        OP_SEARCH  = 6'b111010,
        OP_RAND_WR = 6'b111011,
        OP_IDX_RD  = 6'b111100,
        OP_IDX_WR  = 6'b111101
    } tlb_op_e;

    typedef struct packed {
        logic [ADDR_W-1:0] hi;   // page number in [31:12]
        logic [ADDR_W-1:0] lo;   // frame number in [31:12], usable flag in [0]
    } tlb_entry_t;

    function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:PAGE_LSB];
    endfunction

    // Top quarter of the space never goes through the table.
    function automatic logic in_direct_region(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:ADDR_W-2] == 2'b11;
    endfunction

    function automatic logic is_known_op(input logic [5:0] op);
        return op == OP_SEARCH || op == OP_RAND_WR ||
               op == OP_IDX_RD || op == OP_IDX_WR;
    endfunction

endpackage

// File: rtl/tlb_rand_gen.sv
module tlb_rand_gen #(
    parameter int SPAN  = 28,
    parameter int BASE  = 4,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] pick
);
    logic [IDX_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == IDX_W'(SPAN - 1))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign pick = cnt_q + IDX_W'(BASE);

    // R6: the free-running value stays reduced to the replaceable span
    a_r6_cnt_in_span: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) < SPAN);

endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = 5
) (
    input  logic [PAGE_W-1:0]              key,
    input  logic [ENTRIES-1:0][PAGE_W-1:0] pages,
    input  logic [ENTRIES-1:0]             enable,
    output logic                           hit,
    output logic [IDX_W-1:0]               index,
    output logic [ENTRIES-1:0]             grant
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = enable[g] && (pages[g] == key);
    end

    // Scan downward so the lowest matching slot is the last to win.
    always_comb begin
        hit   = 1'b0;
        index = '0;
        grant = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit      = 1'b1;
                index    = IDX_W'(i);
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [IDX_W-1:0]            waddr,
    input  tlb_entry_t                  wdata,
    output tlb_entry_t [ENTRIES-1:0]    slots
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        tlb_entry_t slot_q;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (we && waddr == IDX_W'(g))
                slot_q <= wdata;
        end
        assign slots[g] = slot_q;
    end

endmodule

// File: rtl/tlb_mmu.sv
module tlb_mmu
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int FIXED   = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [5:0]  cmd_op,
    input  logic [31:0] idx_in,
    input  logic [31:0] hi_in,
    input  logic [31:0] lo_in,
    input  logic [31:0] va,
    output logic        res_valid,
    output logic [31:0] idx_out,
    output logic [31:0] hi_out,
    output logic [31:0] lo_out,
    output logic [31:0] pa,
    output logic        miss
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int SPAN  = ENTRIES - FIXED;

    tlb_entry_t [ENTRIES-1:0]    slots;
    logic [ENTRIES-1:0][PAGE_W-1:0] slot_pages;
    logic [ENTRIES-1:0]          slot_usable;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_fields
        assign slot_pages[g]  = page_of(slots[g].hi);
        assign slot_usable[g] = slots[g].lo[0];
    end

    // Command decode
    logic             do_search, do_rand, do_rd, do_wr, known;
    logic [IDX_W-1:0] sel_idx, rand_pick, waddr;

    assign known     = cmd_valid && is_known_op(cmd_op);
    assign do_search = cmd_valid && cmd_op == OP_SEARCH;
    assign do_rand   = cmd_valid && cmd_op == OP_RAND_WR;
    assign do_rd     = cmd_valid && cmd_op == OP_IDX_RD;
    assign do_wr     = cmd_valid && cmd_op == OP_IDX_WR;
    assign sel_idx   = idx_in[IDX_W-1:0];
    assign waddr     = do_rand ? rand_pick : sel_idx;

    tlb_rand_gen #(.SPAN(SPAN), .BASE(FIXED), .IDX_W(IDX_W)) u_rand (
        .clk  (clk),
        .rst  (rst),
        .pick (rand_pick)
    );

    tlb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (do_rand || do_wr),
        .waddr (waddr),
        .wdata ('{hi: hi_in, lo: lo_in}),
        .slots (slots)
    );

    // Maintenance search: every slot takes part, usable or not.
    logic             s_hit;
    logic [IDX_W-1:0] s_idx;
    logic [ENTRIES-1:0] s_grant;

    tlb_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_search (
        .key    (page_of(hi_in)),
        .pages  (slot_pages),
        .enable ({ENTRIES{1'b1}}),
        .hit    (s_hit),
        .index  (s_idx),
        .grant  (s_grant)
    );

    // Translation lookup: only usable slots take part.
    logic             t_hit;
    logic [IDX_W-1:0] t_idx;
    logic [ENTRIES-1:0] t_grant;

    tlb_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_xlate (
        .key    (page_of(va)),
        .pages  (slot_pages),
        .enable (slot_usable),
        .hit    (t_hit),
        .index  (t_idx),
        .grant  (t_grant)
    );

    // Response registers
    tlb_entry_t rd_slot;
    assign rd_slot = slots[sel_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            idx_out   <= '0;
            hi_out    <= '0;
            lo_out    <= '0;
        end else begin
            res_valid <= known;
            if (known) begin
                idx_out <= idx_in;
                hi_out  <= hi_in;
                lo_out  <= lo_in;
                if (do_search)
                    idx_out <= s_hit ? {{(32-IDX_W){1'b0}}, s_idx} : SEARCH_MISS;
                if (do_rand)
                    idx_out <= {{(32-IDX_W){1'b0}}, rand_pick};
                if (do_rd) begin
                    hi_out <= rd_slot.hi;
                    lo_out <= rd_slot.lo;
                end
            end
        end
    end

    // Combinational translation
    tlb_entry_t t_slot;
    assign t_slot = slots[t_idx];

    always_comb begin
        if (in_direct_region(va)) begin
            pa   = {2'b00, va[29:0]};
            miss = 1'b0;
        end else if (t_hit) begin
            pa   = {t_slot.lo[31:PAGE_LSB], va[PAGE_LSB-1:0]};
            miss = 1'b0;
        end else begin
            pa   = '0;
            miss = 1'b1;
        end
    end

    // R3: an unmatched search leaves the sign-bit sentinel
    a_r3_miss_sentinel: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(do_search) && !$past(s_hit) |-> idx_out == SEARCH_MISS);

    // R6: random replacement never targets a pinned slot
    a_r6_rand_not_pinned: assert property (@(posedge clk) disable iff (rst)
        do_rand |-> int'(waddr) >= FIXED);

    // R8: upper region bypasses the table
    a_r8_direct_bypass: assert property (@(posedge clk) disable iff (rst)
        in_direct_region(va) |-> !miss && pa[31:30] == 2'b00 && pa[29:0] == va[29:0]);

    // R11: each priority encoder grants at most one slot
    a_r11_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s_grant) && $onehot0(t_grant));

    // R10: unknown codes raise no response
    a_r10_no_resp_unknown: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !is_known_op(cmd_op) |=> !res_valid);

    // R7: a translation hit keeps the page offset
    a_r7_offset_kept: assert property (@(posedge clk) disable iff (rst)
        !miss |-> pa[11:0] == va[11:0]);

endmodule

// File: tb/tlb_mmu_tb_top.sv
module tlb_mmu_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [5:0]  cmd_op = '0;
    logic [31:0] idx_in = '0, hi_in = '0, lo_in = '0, va = '0;
    logic        res_valid, miss;
    logic [31:0] idx_out, hi_out, lo_out, pa;

    always #10 clk = ~clk;   // 50 MHz

    tlb_mmu dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .idx_in(idx_in), .hi_in(hi_in), .lo_in(lo_in), .va(va),
        .res_valid(res_valid), .idx_out(idx_out), .hi_out(hi_out),
        .lo_out(lo_out), .pa(pa), .miss(miss)
    );

    localparam logic [5:0] C_SEARCH = 6'b111010;
    localparam logic [5:0] C_RAND   = 6'b111011;
    localparam logic [5:0] C_RD     = 6'b111100;
    localparam logic [5:0] C_WR     = 6'b111101;

    typedef struct {
        int          req;
        logic [31:0] idx;
        logic [31:0] hi;
        logic [31:0] lo;
        bit          idx_range;   // random write: only range of idx known
    } exp_t;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_fail   = 0;
    logic [31:0] last_idx;
    bit          done = 1'b0;

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per response
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (sb_q.size() == 0) begin
                check(10, "unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                last_idx = idx_out;
                if (e.idx_range)
                    check(e.req, "random slot in 4..31",
                          32'(idx_out >= 4 && idx_out <= 31), 32'd1);
                else
                    check(e.req, "idx_out", idx_out, e.idx);
                check(e.req, "hi_out", hi_out, e.hi);
                check(e.req, "lo_out", lo_out, e.lo);
            end
        end
    end

    // Driver: presents one command and pushes its expectation
    task automatic issue(input logic [5:0] op, input logic [31:0] i,
                         input logic [31:0] h, input logic [31:0] l,
                         input bit expect_resp, input exp_t e);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; idx_in = i; hi_in = h; lo_in = l;
        if (expect_resp) sb_q.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b0;
        @(posedge clk);
    endtask

    task automatic xlate(input int req, input logic [31:0] a,
                         input logic [31:0] exp_pa, input logic exp_miss);
        @(negedge clk);
        va = a;
        #2;
        check(req, "pa", pa, exp_pa);
        check(req, "miss", 32'(miss), 32'(exp_miss));
    endtask

    function automatic exp_t mk(input int r, input logic [31:0] i,
                                input logic [31:0] h, input logic [31:0] l,
                                input bit rng);
        exp_t e;
        e.req = r; e.idx = i; e.hi = h; e.lo = l; e.idx_range = rng;
        return e;
    endfunction

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        check(0, "watchdog expired", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(1, "idx_out after reset", idx_out, 32'h0);
        check(1, "hi_out after reset", hi_out, 32'h0);
        check(1, "lo_out after reset", lo_out, 32'h0);
        check(1, "res_valid after reset", 32'(res_valid), 32'h0);
        xlate(1, 32'h0000_0123, 32'h0, 1'b1);

        // R11: cleared table, page 0 matches every slot: lowest is 0
        issue(C_SEARCH, 32'h5, 32'h0000_0abc, 32'h77, 1, mk(11, 32'h0, 32'h0000_0abc, 32'h77, 0));

        // R4: indexed write, upper index bits ignored (39 -> slot 7)
        issue(C_WR, 32'h0000_0027, 32'h1234_5000, 32'hABCD_E001, 1,
              mk(4, 32'h0000_0027, 32'h1234_5000, 32'hABCD_E001, 0));
        // R5: indexed read of slot 7 through a different high part
        issue(C_RD, 32'hFFFF_FFE7, 32'h0, 32'h0, 1,
              mk(5, 32'hFFFF_FFE7, 32'h1234_5000, 32'hABCD_E001, 0));
        // R2: search hit on slot 7, inputs echoed
        issue(C_SEARCH, 32'h0, 32'h1234_5FFF, 32'h5555_0000, 1,
              mk(2, 32'd7, 32'h1234_5FFF, 32'h5555_0000, 0));
        // R3: search miss
        issue(C_SEARCH, 32'h0, 32'h0BAD_F000, 32'h0, 1,
              mk(3, 32'h8000_0000, 32'h0BAD_F000, 32'h0, 0));

        // R7: translation hit and offset kept
        xlate(7, 32'h1234_5678, 32'hABCD_E678, 1'b0);
        // R7: page held but unusable -> miss
        issue(C_WR, 32'd9, 32'h0002_2000, 32'h0033_3000, 1,
              mk(7, 32'd9, 32'h0002_2000, 32'h0033_3000, 0));
        xlate(7, 32'h0002_2010, 32'h0, 1'b1);

        // R11: two usable slots for one page: 10 and 12, lowest wins
        issue(C_WR, 32'd12, 32'h0044_4000, 32'hCCCC_C001, 1,
              mk(11, 32'd12, 32'h0044_4000, 32'hCCCC_C001, 0));
        issue(C_WR, 32'd10, 32'h0044_4000, 32'hDDDD_D001, 1,
              mk(11, 32'd10, 32'h0044_4000, 32'hDDDD_D001, 0));
        issue(C_SEARCH, 32'h0, 32'h0044_4000, 32'h0, 1,
              mk(11, 32'd10, 32'h0044_4000, 32'h0, 0));
        xlate(11, 32'h0044_4ABC, 32'hDDDD_DABC, 1'b0);

        // R9: slot 8 holds a direct-mapped page; search still finds it
        issue(C_WR, 32'd8, 32'hC000_5000, 32'h0066_6001, 1,
              mk(9, 32'd8, 32'hC000_5000, 32'h0066_6001, 0));
        issue(C_SEARCH, 32'h0, 32'hC000_5123, 32'h0, 1,
              mk(9, 32'd8, 32'hC000_5123, 32'h0, 0));
        // R8: translation of that address bypasses the table
        xlate(8, 32'hC000_5ABC, 32'h0000_5ABC, 1'b0);
        xlate(8, 32'hFFFF_FFFF, 32'h3FFF_FFFF, 1'b0);

        // R10: unknown code with write data to slot 7: no response, no change
        issue(6'b000000, 32'd7, 32'h9999_9000, 32'h9999_9001, 0, mk(10, 0, 0, 0, 0));
        issue(6'b111110, 32'd7, 32'h8888_8000, 32'h8888_8001, 0, mk(10, 0, 0, 0, 0));
        issue(C_RD, 32'd7, 32'h0, 32'h0, 1,
              mk(10, 32'd7, 32'h1234_5000, 32'hABCD_E001, 0));

        // R6: pin slots 0..3, then many random writes
        for (int s = 0; s < 4; s++)
            issue(C_WR, 32'(s), 32'h0100_0000 + 32'(s << 12), 32'h0200_0001 + 32'(s << 12), 1,
                  mk(6, 32'(s), 32'h0100_0000 + 32'(s << 12), 32'h0200_0001 + 32'(s << 12), 0));
        for (int k = 0; k < 40; k++) begin
            logic [31:0] h, l;
            h = 32'h0300_0000 + 32'(k << 12);
            l = 32'h0400_0001 + 32'(k << 12);
            issue(C_RAND, 32'h0, h, l, 1, mk(6, 32'h0, h, l, 1));
            // read back the reported slot
            issue(C_RD, last_idx, 32'h0, 32'h0, 1, mk(6, last_idx, h, l, 0));
            // a few idle cycles vary the counter phase
            repeat (k % 3) @(posedge clk);
        end
        for (int s = 0; s < 4; s++)
            issue(C_RD, 32'(s), 32'h0, 32'h0, 1,
                  mk(6, 32'(s), 32'h0100_0000 + 32'(s << 12), 32'h0200_0001 + 32'(s << 12), 0));

        repeat (3) @(posedge clk);
        check(0, "scoreboard drained", 32'(sb_q.size()), 32'd0);
        finish_run();
    end

endmodule